// File: doc/BRIEF.md
# Four-Stage Register-ALU-Memory Pipeline

This block is a short in-order datapath. Each instruction names two source registers, one destination register, a four-bit operation code and a data-memory word address. The instruction goes through four stages. The first stage fetches both operands from a sixteen-entry register file. The second stage computes one ALU result. The third stage writes that result back to the destination register. The fourth stage stores the same result in a 256-word data memory.

An instruction can be accepted on every clock, so up to four instructions are in flight at once. The destination index, operation code and memory address ride through the pipeline registers with their own data. The block does not detect hazards and does not forward results. The issuing side must therefore place a reader of a register at least three cycles after the instruction that writes it. A combinational read port lets the surrounding logic consume the stored words.

Top module: `rfm_pipe4`

## Requirements
- R1: While `rst` is high at a clock edge, register entry i is loaded with the value i. The pipeline is emptied by the same edge, so `wb_valid` and `mem_we` are low in the following cycle.
- R2: Encoding of `in_func`: 0 gives A+B, 1 gives A-B, 2 gives the low 16 bits of A*B, 3 gives A&B, 4 gives A|B, 5 gives A^B, 6 gives -A, and 7 gives A shifted right logically by one bit. Codes 8 to 15 give zero. All results are modulo 2^16.
- R3: Operands are sampled at the edge that accepts the instruction. If the register file writes the same entry on that edge, the operand is the value from before the write.
- R4: For an instruction accepted at edge k, `wb_valid`, `wb_rd` and `wb_data` show its result after edge k+1. The register entry is written at edge k+2, so an instruction accepted at edge k+3 or later reads the new value.
- R5: After edge k+2, `mem_we`, `mem_addr` and `mem_wdata` show the store. `mem_wdata` equals the earlier `wb_data`. The word is written at edge k+3 and can then be read through `dm_raddr`/`dm_rdata`.
- R6: One instruction can be accepted per clock. Each in-flight instruction writes its own destination register and memory address, in the order the instructions were issued.
- R7: If `in_valid` is low at an edge, nothing is accepted. No register write and no memory write follows from that cycle, and the stored words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_rs1 | input | 4 | First source register index (operand A) |
| in_rs2 | input | 4 | Second source register index (operand B) |
| in_rd | input | 4 | Destination register index |
| in_func | input | 4 | ALU operation code |
| in_addr | input | 8 | Data-memory word address for the store |
| wb_valid | output | 1 | Register write-back in progress |
| wb_rd | output | 4 | Register being written |
| wb_data | output | 16 | Value being written to the register |
| mem_we | output | 1 | Data-memory store in progress |
| mem_addr | output | 8 | Word address being stored |
| mem_wdata | output | 16 | Value being stored |
| dm_raddr | input | 8 | Data-memory read address |
| dm_rdata | output | 16 | Data-memory word at `dm_raddr` (combinational) |

## Verification
The assertions run on every cycle and cover the pipeline timing. They check that a write-back appears exactly two cycles after each accepted instruction and that no write-back appears after an idle cycle. They check that the store follows one cycle later with the same value, that the destination and address fields stay aligned with their own instruction, and that reset empties the pipeline. The bench scenarios cover the arithmetic itself. They check each operation code against values computed from the reset contents of the register file. They also check that a result is really written back and read by later instructions, that a same-edge read returns the old value, and that back-to-back instructions fill memory correctly.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    localparam int FUNC_W      = 4;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_RF_DEEP = 16;
    localparam int DEF_DM_DEEP = 256;

    typedef enum logic [FUNC_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_NEG = 4'd6,
        OP_SHR = 4'd7
    } alu_op_e;

endpackage

// File: rtl/rfm_regfile.sv
module rfm_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     ra1,
    input  logic [AW-1:0]     ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DATA_W-1:0] wd
);
    logic [DATA_W-1:0] entry [DEPTH];

    // Each entry resets to its own index.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[i] <= DATA_W'(i);
            end else if (we && (wa == AW'(i))) begin
                entry[i] <= wd;
            end
        end
    end

    // Read before write: the reads see the value from before the edge.
    assign rd1 = entry[ra1];
    assign rd2 = entry[ra2];
endmodule

// File: rtl/rfm_alu.sv
module rfm_alu
    import rfm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FUNC_W-1:0] func,
    output logic [DATA_W-1:0] z
);
    always_comb begin
        case (alu_op_e'(func))
            OP_ADD:  z = a + b;
            OP_SUB:  z = a - b;
            OP_MUL:  z = a * b;
            OP_AND:  z = a & b;
            OP_OR:   z = a | b;
            OP_XOR:  z = a ^ b;
            OP_NEG:  z = '0 - a;
            OP_SHR:  z = a >> 1;
            default: z = '0;
        endcase
    end
endmodule

// File: rtl/rfm_dmem.sv
module rfm_dmem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [AW-1:0]     ra,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            word[wa] <= wd;
        end
    end

    assign rdata = word[ra];
endmodule

// File: rtl/rfm_pipe4.sv
module rfm_pipe4
    import rfm_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int RF_DEPTH = DEF_RF_DEEP,
    parameter int DM_DEPTH = DEF_DM_DEEP,
    localparam int RF_AW   = $clog2(RF_DEPTH),
    localparam int DM_AW   = $clog2(DM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RF_AW-1:0]  in_rs1,
    input  logic [RF_AW-1:0]  in_rs2,
    input  logic [RF_AW-1:0]  in_rd,
    input  logic [FUNC_W-1:0] in_func,
    input  logic [DM_AW-1:0]  in_addr,
    output logic              wb_valid,
    output logic [RF_AW-1:0]  wb_rd,
    output logic [DATA_W-1:0] wb_data,
    output logic              mem_we,
    output logic [DM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DM_AW-1:0]  dm_raddr,
    output logic [DATA_W-1:0] dm_rdata
);
    // Pipeline register contents: operand stage, result stage, store stage.
    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [RF_AW-1:0]  rd;
        logic [FUNC_W-1:0] func;
        logic [DM_AW-1:0]  addr;
    } opnd_t;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] z;
        logic [RF_AW-1:0]  rd;
        logic [DM_AW-1:0]  addr;
    } rslt_t;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] z;
        logic [DM_AW-1:0]  addr;
    } store_t;

    opnd_t  s1_q;
    rslt_t  s2_q;
    store_t s3_q;

    logic [DATA_W-1:0] rf_a, rf_b, alu_z;

    rfm_regfile #(.DATA_W(DATA_W), .DEPTH(RF_DEPTH), .AW(RF_AW)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (in_rs1),
        .ra2 (in_rs2),
        .rd1 (rf_a),
        .rd2 (rf_b),
        .we  (s2_q.v),
        .wa  (s2_q.rd),
        .wd  (s2_q.z)
    );

    rfm_alu #(.DATA_W(DATA_W)) u_alu (
        .a    (s1_q.a),
        .b    (s1_q.b),
        .func (s1_q.func),
        .z    (alu_z)
    );

    rfm_dmem #(.DATA_W(DATA_W), .DEPTH(DM_DEPTH), .AW(DM_AW)) u_dm (
        .clk   (clk),
        .we    (s3_q.v),
        .wa    (s3_q.addr),
        .wd    (s3_q.z),
        .ra    (dm_raddr),
        .rdata (dm_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q.v    <= in_valid;
            s1_q.a    <= rf_a;
            s1_q.b    <= rf_b;
            s1_q.rd   <= in_rd;
            s1_q.func <= in_func;
            s1_q.addr <= in_addr;

            s2_q.v    <= s1_q.v;
            s2_q.z    <= alu_z;
            s2_q.rd   <= s1_q.rd;
            s2_q.addr <= s1_q.addr;

            s3_q.v    <= s2_q.v;
            s3_q.z    <= s2_q.z;
            s3_q.addr <= s2_q.addr;
        end
    end

    assign wb_valid  = s2_q.v;
    assign wb_rd     = s2_q.rd;
    assign wb_data   = s2_q.z;
    assign mem_we    = s3_q.v;
    assign mem_addr  = s3_q.addr;
    assign mem_wdata = s3_q.z;
endmodule

// File: rtl/rfm_pipe4_chk.sv
module rfm_pipe4_chk #(
    parameter int DATA_W = 16,
    parameter int RF_AW  = 4,
    parameter int DM_AW  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [RF_AW-1:0]  in_rd,
    input logic [DM_AW-1:0]  in_addr,
    input logic              wb_valid,
    input logic [RF_AW-1:0]  wb_rd,
    input logic [DATA_W-1:0] wb_data,
    input logic              mem_we,
    input logic [DM_AW-1:0]  mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    AST_RESET_EMPTIES: assert property (@(posedge clk) rst |=> (!wb_valid && !mem_we)); // R1

    AST_WB_TWO_LATER: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 wb_valid); // R4

    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !wb_valid); // R7

    AST_STORE_FOLLOWS_WB: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> (mem_we && mem_wdata == $past(wb_data))); // R5

    AST_NO_STORE_WITHOUT_WB: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |=> !mem_we); // R7

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (wb_rd == $past(in_rd, 2))); // R6

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 (mem_addr == $past(in_addr, 3))); // R6
endmodule

bind rfm_pipe4 rfm_pipe4_chk #(.DATA_W(DATA_W), .RF_AW(RF_AW), .DM_AW(DM_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_rd     (in_rd),
    .in_addr   (in_addr),
    .wb_valid  (wb_valid),
    .wb_rd     (wb_rd),
    .wb_data   (wb_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/rfm_pipe4_bench.sv
module rfm_pipe4_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_rs1 = '0, in_rs2 = '0, in_rd = '0, in_func = '0;
    logic [7:0]  in_addr = '0, dm_raddr = '0;
    logic        wb_valid, mem_we;
    logic [3:0]  wb_rd;
    logic [7:0]  mem_addr;
    logic [15:0] wb_data, mem_wdata, dm_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rfm_pipe4 u_rfm_pipe4 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_rd(in_rd), .in_func(in_func), .in_addr(in_addr), .wb_valid(wb_valid),
        .wb_rd(wb_rd), .wb_data(wb_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dm_raddr(dm_raddr), .dm_rdata(dm_rdata)
    );

    typedef struct packed {
        logic [3:0]  rs1;
        logic [3:0]  rs2;
        logic [3:0]  rd;
        logic [3:0]  func;
        logic [7:0]  addr;
        logic [15:0] exp;
    } vec_t;

    // Register i holds i after reset (R1); results per R2.
    localparam vec_t VECS [9] = '{
        '{4'd3, 4'd5, 4'd8,  4'd0, 8'h10, 16'd8},
        '{4'd2, 4'd5, 4'd9,  4'd1, 8'h11, 16'hFFFD},
        '{4'd7, 4'd6, 4'd10, 4'd2, 8'h12, 16'd42},
        '{4'd6, 4'd3, 4'd11, 4'd3, 8'h13, 16'd2},
        '{4'd4, 4'd1, 4'd12, 4'd4, 8'h14, 16'd5},
        '{4'd7, 4'd2, 4'd13, 4'd5, 8'h15, 16'd5},
        '{4'd1, 4'd0, 4'd14, 4'd6, 8'h16, 16'hFFFF},
        '{4'd7, 4'd0, 4'd15, 4'd7, 8'h17, 16'd3},
        '{4'd7, 4'd7, 4'd8,  4'd9, 8'h18, 16'd0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] s1, input logic [3:0] s2,
                         input logic [3:0] d, input logic [3:0] f, input logic [7:0] ad);
        in_valid = v; in_rs1 = s1; in_rs2 = s2; in_rd = d; in_func = f; in_addr = ad;
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    // Issue, then check write-back, store and memory word at their cycles.
    task automatic run_one(input logic [3:0] s1, input logic [3:0] s2, input logic [3:0] d,
                           input logic [3:0] f, input logic [7:0] ad, input logic [15:0] exp,
                           input string tag);
        @(negedge clk); drive(1'b1, s1, s2, d, f, ad);
        @(negedge clk); idle();
        @(negedge clk);
        check({tag, " wb_valid"}, 16'(wb_valid), 16'd1);
        check({tag, " wb_rd"}, 16'(wb_rd), 16'(d));
        check({tag, " wb_data"}, wb_data, exp);
        @(negedge clk);
        check({tag, " R5 mem_we"}, 16'(mem_we), 16'd1);
        check({tag, " R5 mem_addr"}, 16'(mem_addr), 16'(ad));
        check({tag, " R5 mem_wdata"}, mem_wdata, exp);
        @(negedge clk);
        dm_raddr = ad; #1;
        check({tag, " R5 stored word"}, dm_rdata, exp);
    endtask

    localparam logic [15:0] B2B_EXP [4] = '{16'd3, 16'd5, 16'd3, 16'd2};

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset wb_valid", 16'(wb_valid), 16'd0);
        check("R1 reset mem_we", 16'(mem_we), 16'd0);

        // Table walk: R2 encodings on reset register values (R1).
        foreach (VECS[i]) begin
            run_one(VECS[i].rs1, VECS[i].rs2, VECS[i].rd, VECS[i].func,
                    VECS[i].addr, VECS[i].exp, "R2");
        end

        // R4: results written back are read by later instructions.
        run_one(4'd10, 4'd9, 4'd11, 4'd2, 8'h19, 16'hFF82, "R4 dep mul");
        run_one(4'd8, 4'd7, 4'd12, 4'd0, 8'h1A, 16'd7, "R4 dep code9");

        // R6: four back-to-back instructions.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) check("R6 wb_data b2b", wb_data, B2B_EXP[i-2]);
            case (i)
                0: drive(1'b1, 4'd1, 4'd2, 4'd4, 4'd0, 8'h20);
                1: drive(1'b1, 4'd3, 4'd6, 4'd5, 4'd5, 8'h21);
                2: drive(1'b1, 4'd1, 4'd2, 4'd7, 4'd4, 8'h22);
                3: drive(1'b1, 4'd3, 4'd1, 4'd8, 4'd1, 8'h23);
                default: idle();
            endcase
        end
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            dm_raddr = 8'h20 + 8'(i); #1;
            check("R6 b2b stored", dm_rdata, B2B_EXP[i]);
        end
        run_one(4'd4, 4'd5, 4'd9, 4'd0, 8'h24, 16'd8, "R6 rd fields");

        // R3: read on the edge of the write sees the old value.
        @(negedge clk); drive(1'b1, 4'd1, 4'd1, 4'd3, 4'd0, 8'h28);
        @(negedge clk); idle();
        @(negedge clk);
        check("R3 writer wb_data", wb_data, 16'd2);
        drive(1'b1, 4'd3, 4'd0, 4'd12, 4'd0, 8'h30);
        @(negedge clk); drive(1'b1, 4'd3, 4'd0, 4'd13, 4'd0, 8'h31);
        @(negedge clk); idle();
        check("R3 same-edge read old", wb_data, 16'd3);
        @(negedge clk);
        check("R4 next read new", wb_data, 16'd2);

        // R7: idle cycles with live fields write nothing.
        repeat (3) @(negedge clk);
        drive(1'b0, 4'd1, 4'd1, 4'd0, 4'd0, 8'h10);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R7 no wb", 16'(wb_valid), 16'd0);
            check("R7 no store", 16'(mem_we), 16'd0);
        end
        dm_raddr = 8'h10; #1;
        check("R7 word kept", dm_rdata, 16'd8);
        run_one(4'd0, 4'd0, 4'd14, 4'd0, 8'h32, 16'd0, "R7 r0 kept");

        // R1: reset in flight empties the pipe and restores registers.
        @(negedge clk); drive(1'b1, 4'd5, 4'd5, 4'd6, 4'd0, 8'h40);
        @(negedge clk); idle(); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R1 flushed wb", 16'(wb_valid), 16'd0);
            check("R1 flushed store", 16'(mem_we), 16'd0);
            @(negedge clk);
        end
        run_one(4'd3, 4'd4, 4'd15, 4'd0, 8'h41, 16'd7, "R1 regs restored");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule